// File: doc/BRIEF.md
# Delay-Line Calibration and Receive Phase Tuner

This block prepares the receive sampling point of a high-speed card interface in two steps. First it calibrates a programmable delay line. It steps the per-cell delay code upward from zero and, for each code, waits for the line to report a measured length vector. The first code whose measurement is usable fixes both the delay code and the highest phase tap worth trying.

Second, it walks the receive phase from tap 0 to that highest tap. At each tap it asks an external tuning-command checker for a pass or fail verdict. It then programs the centre of the longest unbroken run of passing taps.

Tuning only runs when the card interface is in one of its two fastest timing modes and the card clock is above 50 MHz. Otherwise a start request completes immediately. Failures end with an error flag and a code that tells a calibration failure apart from a sweep in which no tap passed.

Top module: `dlcal_tuner`

## Requirements
- R1: While reset is high and after its release, `done`, `err`, `err_code`, `chk_req`, `unit_code`, `phase_sel` and `chosen_phase` are all zero.
- R2: A `start` seen while `bus_mode` is neither 6 nor 7, or while `card_clk_khz` is 50000 or less, raises `done` on the next clock edge with `err` low. `chk_req` stays low and `unit_code` is unchanged.
- R3: During calibration, `unit_code` begins at 0 and only ever increases by one. `phase_sel` holds 12 (tap count plus one) whenever `unit_code` changes.
- R4: For each delay code, the block waits at most `TIMEOUT_CYC` cycles for `len_valid`. When the wait expires, it advances to the next code.
- R5: A measurement is accepted only if `len_vec` is nonzero and below 2048. A zero value or a value of 2048 or more advances to the next code. On acceptance, the highest phase tap becomes the index of the highest set bit of `len_vec`.
- R6: If none of the codes 0 to 127 is accepted, `err` rises with `err_code` = 2'b01 and `done` stays low.
- R7: Every tap from 0 to the highest tap is tried once, in increasing order. `chk_req` is held high, with `phase_sel` stable, until `chk_ack` is seen. `chk_pass` is sampled with `chk_ack`.
- R8: The result is the last tap of the longest run of passes minus half that run's length, rounded down. Among runs of equal length the earliest one is kept. This value is driven on `phase_sel` and `chosen_phase` when `done` rises.
- R9: If no tap passes, `err` rises with `err_code` = 2'b10 and `done` stays low.
- R10: `start` is ignored while a run is in progress. `done` and `err` stay set until the next accepted `start`, and are never high together.
- R11: After a successful run, `unit_code` keeps the accepted delay code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a tuning run (accepted when idle) |
| bus_mode | input | MODE_W | Current card timing mode code |
| card_clk_khz | input | CLKF_W | Current card clock frequency in kHz |
| unit_code | output | UNIT_W | Per-cell delay code to the delay line |
| phase_sel | output | PH_W | Phase tap select to the delay line |
| len_valid | input | 1 | Delay line length measurement valid |
| len_vec | input | LEN_W | Delay line measured length vector |
| chk_req | output | 1 | Request a tuning-command verdict at the current tap |
| chk_ack | input | 1 | Verdict available |
| chk_pass | input | 1 | Verdict: 1 pass, 0 fail |
| done | output | 1 | Run finished successfully or was skipped |
| err | output | 1 | Run failed |
| err_code | output | 2 | 01 calibration failed, 10 no passing tap |
| chosen_phase | output | PH_W | Selected phase tap |

## Verification
Pass maps are drawn at random and mixed with directed cases. An all-pass map checks the centre arithmetic at full width. Two equal runs separate first-found from last-found tie handling. A single passing tap at tap 0 exposes off-by-one errors in the run end. An all-fail map exercises the no-tap error.

Calibration stimulus varies what comes before the accepted code: silence (timeouts), a zero length, or a length of 2048 and above. This checks that each kind advances the sweep. It also checks that the boundary value 2048 is rejected while 1 and 2047 are accepted.

A sweep accepted only at code 127, and one never accepted, bracket the end of the code range. Runs in slow modes and at exactly 50 MHz check the skip condition.

// File: rtl/dlcal_pkg.sv
package dlcal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAL_SET,
    ST_CAL_WAIT,
    ST_TUNE_SET,
    ST_TUNE_REQ,
    ST_TUNE_EVAL,
    ST_APPLY
  } tstate_e;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'b00,
    ERR_CAL    = 2'b01,
    ERR_NOPASS = 2'b10
  } terr_e;

endpackage

// File: rtl/dlcal_timer.sv
module dlcal_timer #(
  parameter int CYC = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= CW'(CYC);
    else if (cnt != '0) cnt <= cnt - CW'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/dlcal_lenchk.sv
module dlcal_lenchk #(
  parameter int NTAPS = 11,
  parameter int LEN_W = 12,
  parameter int PH_W  = 4
) (
  input  logic [LEN_W-1:0] len_vec,
  output logic             ok,
  output logic [PH_W-1:0]  top_idx
);
  localparam logic [LEN_W:0] LIMIT = (LEN_W+1)'(1) << NTAPS;

  logic [LEN_W-1:0] hit;

  // one-hot marker of the highest set bit
  genvar g;
  generate
    for (g = 0; g < LEN_W; g++) begin : g_top
      if (g == LEN_W - 1) begin : g_msb
        assign hit[g] = len_vec[g];
      end else begin : g_low
        assign hit[g] = len_vec[g] & ~(|len_vec[LEN_W-1:g+1]);
      end
    end
  endgenerate

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < LEN_W; i++) begin
      if (hit[i]) top_idx = PH_W'(i);
    end
  end

  assign ok = (len_vec != '0) && ({1'b0, len_vec} < LIMIT);
endmodule

// File: rtl/dlcal_runtrack.sv
module dlcal_runtrack #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         upd,
  input  logic         pass,
  input  logic [W-1:0] phase,
  output logic [W-1:0] best_len,
  output logic [W-1:0] centre
);
  logic [W-1:0] cur_len;
  logic [W-1:0] best_end;
  logic [W-1:0] cur_nx;

  assign cur_nx = cur_len + W'(1);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cur_len  <= '0;
      best_len <= '0;
      best_end <= '0;
    end else if (upd) begin
      if (pass) begin
        cur_len <= cur_nx;
        // strict compare keeps the earliest run on ties
        if (cur_nx > best_len) begin
          best_len <= cur_nx;
          best_end <= phase;
        end
      end else begin
        cur_len <= '0;
      end
    end
  end

  assign centre = best_end - (best_len >> 1);
endmodule

// File: rtl/dlcal_tuner.sv
module dlcal_tuner
  import dlcal_pkg::*;
#(
  parameter int NTAPS       = 11,
  parameter int LEN_W       = 12,
  parameter int UNIT_W      = 7,
  parameter int TIMEOUT_CYC = 100000,
  parameter int CLKF_W      = 18,
  parameter int CLK_MIN_KHZ = 50000,
  parameter int MODE_W      = 3,
  parameter int FAST_MODE_A = 6,
  parameter int FAST_MODE_B = 7,
  parameter int PH_W        = $clog2(NTAPS + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MODE_W-1:0] bus_mode,
  input  logic [CLKF_W-1:0] card_clk_khz,
  output logic [UNIT_W-1:0] unit_code,
  output logic [PH_W-1:0]   phase_sel,
  input  logic              len_valid,
  input  logic [LEN_W-1:0]  len_vec,
  output logic              chk_req,
  input  logic              chk_ack,
  input  logic              chk_pass,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code,
  output logic [PH_W-1:0]   chosen_phase
);
  localparam logic [UNIT_W-1:0] UNIT_MAX = {UNIT_W{1'b1}};
  localparam logic [PH_W-1:0]   CAL_PH   = PH_W'(NTAPS + 1);

  tstate_e          st;
  logic [PH_W-1:0]  ph;
  logic [PH_W-1:0]  ph_max;
  logic             qualify;
  logic             tmr_load;
  logic             tmr_exp;
  logic             len_ok;
  logic [PH_W-1:0]  len_top;
  logic             trk_clear;
  logic             trk_upd;
  logic [PH_W-1:0]  trk_best;
  logic [PH_W-1:0]  trk_centre;

  assign qualify = ((bus_mode == MODE_W'(FAST_MODE_A)) ||
                    (bus_mode == MODE_W'(FAST_MODE_B))) &&
                   (card_clk_khz > CLKF_W'(CLK_MIN_KHZ));

  assign tmr_load  = (st == ST_CAL_SET);
  assign trk_clear = (st == ST_CAL_SET);
  assign trk_upd   = (st == ST_TUNE_REQ) && chk_ack;

  dlcal_timer #(.CYC(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .expired (tmr_exp)
  );

  dlcal_lenchk #(.NTAPS(NTAPS), .LEN_W(LEN_W), .PH_W(PH_W)) u_lenchk (
    .len_vec (len_vec),
    .ok      (len_ok),
    .top_idx (len_top)
  );

  dlcal_runtrack #(.W(PH_W)) u_track (
    .clk      (clk),
    .rst      (rst),
    .clear    (trk_clear),
    .upd      (trk_upd),
    .pass     (chk_pass),
    .phase    (ph),
    .best_len (trk_best),
    .centre   (trk_centre)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      unit_code    <= '0;
      phase_sel    <= '0;
      chk_req      <= 1'b0;
      done         <= 1'b0;
      err          <= 1'b0;
      err_code     <= ERR_NONE;
      chosen_phase <= '0;
      ph           <= '0;
      ph_max       <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            done     <= 1'b0;
            err      <= 1'b0;
            err_code <= ERR_NONE;
            if (qualify) begin
              unit_code <= '0;
              phase_sel <= CAL_PH;
              st        <= ST_CAL_SET;
            end else begin
              done         <= 1'b1;
              chosen_phase <= '0;
            end
          end
        end
        ST_CAL_SET: begin
          st <= ST_CAL_WAIT;
        end
        ST_CAL_WAIT: begin
          if (len_valid && len_ok) begin
            ph_max <= len_top;
            ph     <= '0;
            st     <= ST_TUNE_SET;
          end else if (len_valid || tmr_exp) begin
            if (unit_code == UNIT_MAX) begin
              err      <= 1'b1;
              err_code <= ERR_CAL;
              st       <= ST_IDLE;
            end else begin
              unit_code <= unit_code + UNIT_W'(1);
              st        <= ST_CAL_SET;
            end
          end
        end
        ST_TUNE_SET: begin
          phase_sel <= ph;
          chk_req   <= 1'b1;
          st        <= ST_TUNE_REQ;
        end
        ST_TUNE_REQ: begin
          if (chk_ack) begin
            chk_req <= 1'b0;
            if (ph == ph_max) begin
              st <= ST_TUNE_EVAL;
            end else begin
              ph <= ph + PH_W'(1);
              st <= ST_TUNE_SET;
            end
          end
        end
        ST_TUNE_EVAL: begin
          if (trk_best == '0) begin
            err      <= 1'b1;
            err_code <= ERR_NOPASS;
            st       <= ST_IDLE;
          end else begin
            phase_sel    <= trk_centre;
            chosen_phase <= trk_centre;
            st           <= ST_APPLY;
          end
        end
        ST_APPLY: begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dlcal_tuner_chk.sv
module dlcal_tuner_chk #(
  parameter int NTAPS  = 11,
  parameter int UNIT_W = 7,
  parameter int PH_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [UNIT_W-1:0] unit_code,
  input logic [PH_W-1:0]   phase_sel,
  input logic              chk_req,
  input logic              chk_ack,
  input logic              done,
  input logic              err,
  input logic [1:0]        err_code,
  input logic [PH_W-1:0]   chosen_phase
);
  localparam logic [PH_W-1:0] CAL_PH = PH_W'(NTAPS + 1);

  p_cal_phase_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(unit_code) |-> (phase_sel == CAL_PH));

  p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (chk_req && !chk_ack) |=> chk_req);

  p_phase_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (chk_req && !chk_ack) |=> $stable(phase_sel));

  p_applied_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(done) && !$past(start)) |-> (phase_sel == chosen_phase));

  p_chosen_range_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (chosen_phase < PH_W'(NTAPS)));

  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  p_err_code_r6: assert property (@(posedge clk) disable iff (rst)
    err |-> (err_code != 2'b00));

  p_done_code_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (err_code == 2'b00));
endmodule

bind dlcal_tuner dlcal_tuner_chk #(
  .NTAPS (NTAPS),
  .UNIT_W(UNIT_W),
  .PH_W  (PH_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .unit_code    (unit_code),
  .phase_sel    (phase_sel),
  .chk_req      (chk_req),
  .chk_ack      (chk_ack),
  .done         (done),
  .err          (err),
  .err_code     (err_code),
  .chosen_phase (chosen_phase)
);

// File: tb/dlcal_tuner_test.sv
module dlcal_tuner_test;
  localparam int NT  = 11;
  localparam int PHW = 4;
  localparam int UW  = 7;
  localparam int LW  = 12;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [2:0]     bus_mode = 3'd6;
  logic [17:0]    card_clk_khz = 18'd100000;
  logic [UW-1:0]  unit_code;
  logic [PHW-1:0] phase_sel;
  logic           len_valid = 1'b0;
  logic [LW-1:0]  len_vec = '0;
  logic           chk_req;
  logic           chk_ack = 1'b0;
  logic           chk_pass = 1'b0;
  logic           done;
  logic           err;
  logic [1:0]     err_code;
  logic [PHW-1:0] chosen_phase;

  int checks = 0;
  int errors = 0;

  // scenario description
  int          thr;
  logic [11:0] len_good;
  logic [1:0]  kind [0:127];
  logic [15:0] pass_map;
  logic        mid_start;

  // model bookkeeping
  logic [UW-1:0]  last_unit;
  int             dcnt, rc, seq_bad, order_bad, nreq;
  logic [PHW-1:0] exp_ph;

  always #2 clk = ~clk;

  dlcal_tuner #(.TIMEOUT_CYC(40)) uut (
    .clk(clk), .rst(rst), .start(start), .bus_mode(bus_mode),
    .card_clk_khz(card_clk_khz), .unit_code(unit_code), .phase_sel(phase_sel),
    .len_valid(len_valid), .len_vec(len_vec), .chk_req(chk_req),
    .chk_ack(chk_ack), .chk_pass(chk_pass), .done(done), .err(err),
    .err_code(err_code), .chosen_phase(chosen_phase)
  );

  // delay line and tuning-command checker models
  always @(negedge clk) begin
    if (rst) begin
      len_valid = 1'b0;
      len_vec   = '0;
      last_unit = '0;
      dcnt      = 0;
      chk_ack   = 1'b0;
      rc        = 0;
    end else begin
      if (unit_code != last_unit) begin
        if (unit_code != last_unit + UW'(1) && unit_code != '0) seq_bad++;
        last_unit = unit_code;
        len_valid = 1'b0;
        dcnt      = 0;
      end else if (phase_sel == 4'd12 && !len_valid) begin
        dcnt++;
        if (dcnt == 3) begin
          if (int'(unit_code) < thr) begin
            if (kind[unit_code] == 2'd1) begin
              len_valid = 1'b1; len_vec = 12'h000;
            end else if (kind[unit_code] == 2'd2) begin
              len_valid = 1'b1; len_vec = 12'h800 | 12'($urandom & 32'h7FF);
            end
          end else if (int'(unit_code) == thr) begin
            len_valid = 1'b1; len_vec = len_good;
          end
        end
      end
      if (chk_ack) chk_ack = 1'b0;
      else if (chk_req) begin
        rc++;
        if (rc == 2) begin
          rc = 0;
          chk_ack  = 1'b1;
          chk_pass = pass_map[phase_sel];
          if (phase_sel != exp_ph) order_bad++;
          exp_ph = exp_ph + 4'd1;
          nreq++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic calc(input logic [11:0] L, input logic [15:0] pm,
                      output int mx, output int best, output int fin);
    int cur, bend;
    mx = 0;
    for (int i = 0; i < 12; i++) if (L[i]) mx = i;
    cur = 0; best = 0; bend = 0;
    for (int p = 0; p <= mx; p++) begin
      if (pm[p]) begin
        cur++;
        if (cur > best) begin best = cur; bend = p; end
      end else cur = 0;
    end
    fin = bend - best / 2;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    seq_bad = 0; order_bad = 0; nreq = 0; exp_ph = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_case(input int t, input logic [11:0] L, input logic [15:0] pm,
                          input bit had_tmo);
    int mx, best, fin, cyc;
    thr = t; len_good = L; pass_map = pm;
    bus_mode = 3'd7; card_clk_khz = 18'd100000;
    do_reset();
    start = 1'b1; @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!(done || err) && cyc < 30000) begin
      @(negedge clk);
      cyc++;
      if (mid_start && cyc == 12) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    check(cyc < 30000, "R4 run finished", cyc, 30000);
    calc(L, pm, mx, best, fin);
    if (t > 127) begin
      check(err && !done, "R6 err", err, 1);
      check(err_code == 2'b01, "R6 code", err_code, 1);
    end else if (best == 0) begin
      check(err && !done, "R9 err", err, 1);
      check(err_code == 2'b10, "R9 code", err_code, 2);
      check(nreq == mx + 1, "R7 taps tried", nreq, mx + 1);
    end else begin
      check(done && !err, "R8 done", done, 1);
      check(chosen_phase == fin, "R8 chosen", chosen_phase, fin);
      check(phase_sel == fin, "R8 applied", phase_sel, fin);
      check(unit_code == t, had_tmo ? "R4 R11 unit" : "R5 R11 unit", unit_code, t);
      check(nreq == mx + 1, "R7 taps tried", nreq, mx + 1);
      check(order_bad == 0, "R7 tap order", order_bad, 0);
      check(seq_bad == 0, "R3 code sequence", seq_bad, 0);
    end
    repeat (5) @(negedge clk);
    check((done || err) && !(done && err), "R10 sticky", done, 1);
  endtask

  task automatic skip_case(input logic [2:0] m, input logic [17:0] f);
    do_reset();
    bus_mode = m; card_clk_khz = f;
    start = 1'b1; @(negedge clk); start = 1'b0;
    check(done && !err, "R2 skip done", done, 1);
    check(unit_code == 0 && chk_req == 0, "R2 no activity", unit_code, 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    mid_start = 1'b0;
    thr = 0;
    for (int i = 0; i < 128; i++) kind[i] = 2'd0;
    // R1
    repeat (2) @(negedge clk);
    check(done == 0 && err == 0 && err_code == 0 && chk_req == 0, "R1 flags", done, 0);
    check(unit_code == 0 && phase_sel == 0 && chosen_phase == 0, "R1 outputs", phase_sel, 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 0 && unit_code == 0, "R1 after release", done, 0);

    skip_case(3'd3, 18'd100000);
    skip_case(3'd7, 18'd50000);

    run_case(0, 12'h7FF, 16'hFFFF, 1'b0);               // full width, all pass
    kind[0] = 2'd0; kind[1] = 2'd1;
    run_case(2, 12'h400, 16'b0000_0111_0111, 1'b1);     // tie: first run kept
    kind[0] = 2'd2;
    run_case(1, 12'h001, 16'h0001, 1'b0);               // 2048 rejected, 1 accepted
    run_case(0, 12'h0FF, 16'h0000, 1'b0);               // R9 no pass
    for (int i = 0; i < 128; i++) kind[i] = 2'(i % 3);
    run_case(127, 12'h155, 16'h00F0, 1'b1);             // last code accepted
    run_case(200, 12'h001, 16'h0001, 1'b1);             // R6 never accepted
    mid_start = 1'b1;
    kind[0] = 2'd0;
    run_case(1, 12'h0A0, 16'h003C, 1'b1);               // R10 start ignored
    mid_start = 1'b0;

    for (int n = 0; n < 10; n++) begin
      int b;
      logic [11:0] L;
      for (int i = 0; i < 8; i++) kind[i] = 2'($urandom % 3);
      b = $urandom % 11;
      L = 12'((1 << b) | ($urandom & ((1 << b) - 1)));
      run_case($urandom % 8, L, 16'($urandom), 1'b1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule